// File: doc/BRIEF.md
# Register-Mapped Serial Port with Sticky Event Interrupts

This block is a byte-wide asynchronous serial port on a simple 32-bit register bus. Software configures the bit period and interrupt enables through the bus. It sends a byte by writing the data register and reads a received byte from the same register. The serial line uses one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. Every bit lasts a programmable number of clock cycles.

Two sticky event flags live in the status register. The transmit event is set by any write to the data register. The receive event is set when a valid frame is latched. Software clears either flag by writing a one to its bit. The level interrupt output is high when an enabled event is pending. The receiver holds exactly one byte. While the receive event is pending, later frames are thrown away and the held byte is kept. The transmitter has a shift register plus a single holding byte. A data write that finds the holding byte occupied is lost.

The transmitter state machine has four states. From TX_IDLE it goes to TX_START when the holding byte is valid, and loads the shifter. From TX_START it goes to TX_DATA after one bit period. From TX_DATA it goes to TX_STOP after the eighth data bit. From TX_STOP it goes back to TX_IDLE after one bit period. The receiver state machine also has four states. From RX_IDLE it goes to RX_START on a high-to-low edge of the synchronised line. From RX_START it goes to RX_DATA if the line is still low at the half-bit point, and otherwise back to RX_IDLE. From RX_DATA it goes to RX_STOP after eight samples, each taken one bit period apart. From RX_STOP it goes back to RX_IDLE at the stop sample, and the frame is delivered only if that sample is high.

Top module: `uart_evt_top`

## Requirements
- R1: The register index is `bus_addr[4:2]`, and address bits 1:0 are ignored. Index 0 is data, 1 is divisor, 2 is status, 3 is control and 4 is debug. Indices 5 to 7 read as zero, and writes to them change nothing.
- R2: After reset, data, divisor, control and debug read 0. Status reads 0x1. `irq` is 0 and `ser_txd` is 1.
- R3: Divisor, control and debug store and return all 32 written bits.
- R4: Status bit 0 (transmit holding empty) always reads 1. Bit 1 is the receive event and bit 2 is the transmit event. Higher bits read 0.
- R5: A data write transmits the low byte of the write as an 8N1 frame, least significant bit first. Each bit lasts `divisor[15:0]` clock cycles, and values below 2 act as 2.
- R6: Every write to the data register sets the transmit event.
- R7: While a frame is shifting out, one further data write is queued and sent after it. Any write made while the queue slot is full is lost.
- R8: Writing status clears bit 1 and/or bit 2 only where the written value has a one. Other written bits have no effect.
- R9: The receiver detects a falling edge and requires the line to still be low at the half-bit point. It samples each data bit at mid-bit, latches the byte into the data register and sets the receive event. A low pulse shorter than half a bit starts no frame.
- R10: A frame whose stop sample is low is discarded, and the event and data are left unchanged.
- R11: A frame that completes while the receive event is set is dropped, and the held byte is kept.
- R12: `irq` equals (control bit 0 AND receive event) OR (control bit 1 AND transmit event).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |
| ser_txd | output | 1 | Serial transmit line, idle high |
| ser_rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The hardest situation to reach is a frame that completes while an earlier byte is still unacknowledged. The stimulus gets there by leaving the receive event set after one good frame and then driving a second full frame onto `ser_rxd`. The check is that the data register still returns the first byte. A similar case is the lost transmit write. It needs three data writes packed into a few cycles, so that the shifter is busy and the holding byte is full when the third write arrives. A scoreboard queue then confirms that exactly two frames appear on the line.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
    localparam int REG_DATA = 0;
    localparam int REG_DIV  = 1;
    localparam int REG_STAT = 2;
    localparam int REG_CTRL = 3;
    localparam int REG_DBG  = 4;

    localparam int ST_RXEV  = 1;
    localparam int ST_TXEV  = 2;
    localparam int CT_RXIE  = 0;
    localparam int CT_TXIE  = 1;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/uart_evt_tx.sv
module uart_evt_tx
    import uart_evt_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_eff,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_byte,
    output logic              txd
);
    localparam int BIT_W = $clog2(DATA_W);

    tx_state_t         state, state_n;
    logic [DIV_W-1:0]  cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg, hold;
    logic              hold_vld, txd_q, tick;

    assign tick = (cnt == div_eff - DIV_W'(1));
    assign txd  = txd_q;

    always_comb begin
        state_n = state;
        unique case (state)
            TX_IDLE:  if (hold_vld) state_n = TX_START;
            TX_START: if (tick) state_n = TX_DATA;
            TX_DATA:  if (tick && bit_idx == BIT_W'(DATA_W-1)) state_n = TX_STOP;
            TX_STOP:  if (tick) state_n = TX_IDLE;
            default:  state_n = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            hold     <= '0;
            hold_vld <= 1'b0;
            txd_q    <= 1'b1;
        end else begin
            if (state_n != state || tick) cnt <= '0;
            else                          cnt <= cnt + DIV_W'(1);

            if (state == TX_IDLE && hold_vld) begin
                shreg    <= hold;
                hold_vld <= 1'b0;
                bit_idx  <= '0;
            end else if (wr_stb && !hold_vld) begin
                hold     <= wr_byte;
                hold_vld <= 1'b1;
            end

            if (state == TX_DATA && tick) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + BIT_W'(1);
            end

            if (state_n == TX_DATA)
                txd_q <= (state == TX_DATA && tick) ? shreg[1] : shreg[0];
            else
                txd_q <= (state_n != TX_START);
        end
    end

    AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        state == TX_IDLE |-> txd_q);                                     // R5
    AST_TX_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        state == TX_START |-> !txd_q);                                   // R5
    AST_TX_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        hold_vld && wr_stb |=> $stable(hold));                           // R7
endmodule

// File: rtl/uart_evt_rx.sv
module uart_evt_rx
    import uart_evt_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_eff,
    input  logic              rxd,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int BIT_W = $clog2(DATA_W);

    rx_state_t         state, state_n;
    logic [2:0]        sync;
    logic [DIV_W-1:0]  cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              done_q, tick, mid, line, fall;

    assign line    = sync[1];
    assign fall    = sync[2] && !sync[1];
    assign tick    = (cnt == div_eff - DIV_W'(1));
    assign mid     = (cnt == (div_eff >> 1));
    assign rx_done = done_q;
    assign rx_byte = shreg;

    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE:  if (fall) state_n = RX_START;
            RX_START: if (mid) state_n = line ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && bit_idx == BIT_W'(DATA_W-1)) state_n = RX_STOP;
            RX_STOP:  if (tick) state_n = RX_IDLE;
            default:  state_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync    <= 3'b111;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            done_q  <= 1'b0;
        end else begin
            sync <= {sync[1:0], rxd};
            if (state_n != state || tick) cnt <= '0;
            else                          cnt <= cnt + DIV_W'(1);

            if (state == RX_START) bit_idx <= '0;
            if (state == RX_DATA && tick) begin
                shreg   <= {line, shreg[DATA_W-1:1]};
                bit_idx <= bit_idx + BIT_W'(1);
            end
            done_q <= (state == RX_STOP) && tick && line;
        end
    end

    AST_RX_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(state) == RX_STOP);                             // R9
    AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);                                             // R9
endmodule

// File: rtl/uart_evt_top.sv
module uart_evt_top
    import uart_evt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              ser_txd,
    input  logic              ser_rxd
);
    localparam int IDX_W   = ADDR_W - 2;
    localparam int DIV_MIN = 2;

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data_q, rx_byte;
    logic [31:0]       div_q, ctrl_q, dbg_q;
    logic              ev_rx, ev_tx, rx_done;
    logic              wr_data, wr_div, wr_stat, wr_ctrl, wr_dbg, accept;
    logic [DIV_W-1:0]  div_raw, div_eff;
    logic              unused_addr_lo;

    assign idx            = bus_addr[ADDR_W-1:2];
    assign unused_addr_lo = ^bus_addr[1:0];
    assign wr_data = bus_we && idx == IDX_W'(REG_DATA);
    assign wr_div  = bus_we && idx == IDX_W'(REG_DIV);
    assign wr_stat = bus_we && idx == IDX_W'(REG_STAT);
    assign wr_ctrl = bus_we && idx == IDX_W'(REG_CTRL);
    assign wr_dbg  = bus_we && idx == IDX_W'(REG_DBG);
    assign accept  = rx_done && !ev_rx;

    assign div_raw = div_q[DIV_W-1:0];
    assign div_eff = (div_raw < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div_raw;

    uart_evt_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .div_eff(div_eff),
        .wr_stb(wr_data), .wr_byte(bus_wdata[DATA_W-1:0]), .txd(ser_txd)
    );

    uart_evt_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .div_eff(div_eff),
        .rxd(ser_rxd), .rx_done(rx_done), .rx_byte(rx_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            div_q  <= '0;
            ctrl_q <= '0;
            dbg_q  <= '0;
            ev_rx  <= 1'b0;
            ev_tx  <= 1'b0;
        end else begin
            if (wr_div)  div_q  <= bus_wdata;
            if (wr_ctrl) ctrl_q <= bus_wdata;
            if (wr_dbg)  dbg_q  <= bus_wdata;
            if (accept)  data_q <= rx_byte;
            ev_rx <= (ev_rx && !(wr_stat && bus_wdata[ST_RXEV])) || accept;
            ev_tx <= (ev_tx && !(wr_stat && bus_wdata[ST_TXEV])) || wr_data;
        end
    end

    always_comb begin
        case (idx)
            IDX_W'(REG_DATA): bus_rdata = {{(32-DATA_W){1'b0}}, data_q};
            IDX_W'(REG_DIV):  bus_rdata = div_q;
            IDX_W'(REG_STAT): bus_rdata = {29'd0, ev_tx, ev_rx, 1'b1};
            IDX_W'(REG_CTRL): bus_rdata = ctrl_q;
            IDX_W'(REG_DBG):  bus_rdata = dbg_q;
            default:          bus_rdata = '0;
        endcase
    end

    assign irq = (ctrl_q[CT_RXIE] && ev_rx) || (ctrl_q[CT_TXIE] && ev_tx);

    AST_RX_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx |=> $stable(data_q));                                      // R11
    AST_TX_EVT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> ev_tx);                                              // R6
    AST_W1C_RX: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && bus_wdata[ST_RXEV] && ev_rx |=> !ev_rx);              // R8
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q[1:0] != 2'b00);                                   // R12
    AST_THRE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        idx == IDX_W'(REG_STAT) |-> bus_rdata[0]);                       // R4
endmodule

// File: tb/sim_uart_evt_top.sv
`timescale 1ns/1ps
module sim_uart_evt_top;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, ser_txd;
    logic        ser_rxd = 1'b1;

    int checks = 0;
    int errors = 0;
    int bitp = 8;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #(CLK_NS/2) clk = ~clk;

    uart_evt_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .ser_txd(ser_txd), .ser_rxd(ser_rxd)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic expect_rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, req, bus_rdata, exp);
    endtask

    task automatic expect_irq(input logic exp, input string req);
        @(negedge clk);
        check(irq === exp, req, {31'd0, irq}, {31'd0, exp});
    endtask

    // driver: pushes the byte the line should carry, then writes it
    task automatic tx_push(input logic [7:0] b, input bit sent);
        if (sent) exp_q.push_back(b);
        bus_wr(5'h00, {24'd0, b});
    endtask

    task automatic wait_drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (bitp * 14) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic rx_frame(input logic [7:0] b, input logic stop);
        @(negedge clk);
        ser_rxd = 1'b0;
        repeat (bitp) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_rxd = b[i];
            repeat (bitp) @(negedge clk);
        end
        ser_rxd = stop;
        repeat (bitp) @(negedge clk);
        ser_rxd = 1'b1;
        repeat (bitp * 2) @(negedge clk);
    endtask

    // monitor: decode each frame on ser_txd and compare with the queue (R5, R7)
    initial begin
        logic [7:0] got;
        forever begin
            @(negedge ser_txd);
            #(2 + bitp * CLK_NS / 2);
            check(ser_txd === 1'b0, "R5 start bit", {31'd0, ser_txd}, 0);
            for (int i = 0; i < 8; i++) begin
                #(bitp * CLK_NS);
                got[i] = ser_txd;
            end
            #(bitp * CLK_NS);
            check(ser_txd === 1'b1, "R5 stop bit", {31'd0, ser_txd}, 1);
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected frame", {24'd0, got}, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(got === e, "R5 frame byte", {24'd0, got}, {24'd0, e});
            end
        end
    end

    initial begin
        #(200000 * CLK_NS);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        expect_rd(5'h00, 32'h0, "R2 data");
        expect_rd(5'h04, 32'h0, "R2 divisor");
        expect_rd(5'h08, 32'h1, "R2 status");
        expect_rd(5'h0C, 32'h0, "R2 control");
        expect_rd(5'h10, 32'h0, "R2 debug");
        expect_irq(1'b0, "R2 irq");
        check(ser_txd === 1'b1, "R2 txd idle", {31'd0, ser_txd}, 1);

        // R3 storage
        bus_wr(5'h04, 32'h1234_0008);
        bus_wr(5'h0C, 32'hA5A5_0000);
        bus_wr(5'h10, 32'hFFFF_FFFF);
        expect_rd(5'h04, 32'h1234_0008, "R3 divisor");
        expect_rd(5'h0C, 32'hA5A5_0000, "R3 control");
        expect_rd(5'h10, 32'hFFFF_FFFF, "R3 debug");

        // R1 unmapped and low address bits
        bus_wr(5'h14, 32'hFFFF_FFFF);
        bus_wr(5'h1C, 32'h0000_0007);
        expect_rd(5'h14, 32'h0, "R1 index5");
        expect_rd(5'h18, 32'h0, "R1 index6");
        expect_rd(5'h1C, 32'h0, "R1 index7");
        expect_rd(5'h07, 32'h1234_0008, "R1 low bits ignored");
        expect_rd(5'h0B, 32'h1, "R1 status unchanged");
        bus_wr(5'h0C, 32'h0);

        // R5 R6 transmit and event
        tx_push(8'h3C, 1'b1);
        wait_drain("R5 frame delivered");
        expect_rd(5'h08, 32'h5, "R6 tx event set R4");
        expect_irq(1'b0, "R12 disabled");
        bus_wr(5'h0C, 32'h2);
        expect_irq(1'b1, "R12 tx enabled");
        bus_wr(5'h08, 32'hFFFF_FFF9);
        expect_rd(5'h08, 32'h5, "R8 other bits no effect");
        expect_irq(1'b1, "R8 irq kept");
        bus_wr(5'h08, 32'h4);
        expect_rd(5'h08, 32'h1, "R8 tx clear R4");
        expect_irq(1'b0, "R12 cleared");

        // R7 holding byte, third write lost
        tx_push(8'h81, 1'b1);
        tx_push(8'h42, 1'b1);
        tx_push(8'h99, 1'b0);
        wait_drain("R7 two frames only");

        // R5 other divisor
        bus_wr(5'h04, 32'd12);
        bitp = 12;
        tx_push(8'hF0, 1'b1);
        wait_drain("R5 divisor 12");
        bus_wr(5'h04, 32'd8);
        bitp = 8;
        bus_wr(5'h08, 32'h6);
        bus_wr(5'h0C, 32'h1);

        // R9 receive
        rx_frame(8'hA5, 1'b1);
        expect_rd(5'h08, 32'h3, "R9 rx event");
        expect_rd(5'h00, 32'hA5, "R9 rx data");
        expect_irq(1'b1, "R12 rx enabled");

        // R11 dropped while pending
        rx_frame(8'h5A, 1'b1);
        expect_rd(5'h00, 32'hA5, "R11 held byte kept");
        expect_rd(5'h08, 32'h3, "R11 event still set");

        // R10 bad stop
        bus_wr(5'h08, 32'h2);
        expect_irq(1'b0, "R8 rx clear irq");
        rx_frame(8'h77, 1'b0);
        expect_rd(5'h08, 32'h1, "R10 no event");
        expect_rd(5'h00, 32'hA5, "R10 data kept");

        // R9 short glitch
        @(negedge clk);
        ser_rxd = 1'b0;
        repeat (2) @(negedge clk);
        ser_rxd = 1'b1;
        repeat (bitp * 12) @(negedge clk);
        expect_rd(5'h08, 32'h1, "R9 glitch rejected");

        rx_frame(8'h0F, 1'b1);
        expect_rd(5'h00, 32'h0F, "R9 second byte");
        expect_rd(5'h08, 32'h3, "R9 event again");
        bus_wr(5'h0C, 32'h0);
        expect_irq(1'b0, "R12 rx disabled");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule